// File: doc/BRIEF.md
# Card bus strobe timing sequencer

This block runs one host access to a removable card at a time. It splits each access into three phases and counts each in system clocks. Setup runs from address valid to strobe. Strobe length is the minimum time the strobe stays asserted. Hold runs after the strobe negates, while address and write data stay driven. The host raises a request together with the access kind (memory or I/O space, read or write), the address, write data and the timing fields of the window being accessed. The block latches all of these when it accepts the request. It answers with a one-clock acknowledge once the hold phase ends.

In memory space the block uses an output-enable strobe for reads and a write-enable strobe for writes. In I/O space it uses an I/O-read or I/O-write strobe. The card can stretch the strobe with a wait input, which passes through a synchronizer first. The window's timing fields decide whether that wait input is honoured. Every card-side output is active high here. Any pin inversion is done outside the block.

Top module: `card_strobe_seq`

## Requirements
- R1: While reset is held, and after it is released with no request, the acknowledge, chip-enable, address-valid, data-drive enable and all four strobes are low.
- R2: After a request is accepted, chip-enable and address-valid are high with no strobe for exactly the programmed setup count of clocks (a setup of 0 gives no setup clock).
- R3: On an I/O-space write the setup phase lasts the programmed setup count plus one clock.
- R4: The strobe stays asserted for exactly max(length field, 1) clocks when the wait input is not honoured.
- R5: When the window's wait enable is set, the strobe negates at the first clock edge where the programmed length has elapsed and the synchronized wait input is low. A raw wait that drops during strobe clock k (counting from 0) gives a strobe of max(max(length,1), k+3) clocks. When the wait enable is clear, the wait input has no effect on strobe length.
- R6: After the strobe negates, chip-enable stays high with no strobe for max(hold field, 1) clocks.
- R7: Exactly one strobe is asserted, and only while chip-enable is high. The strobe vector {output-enable, write-enable, I/O-read, I/O-write} is 4'b1000 for a memory read, 4'b0100 for a memory write, 4'b0010 for an I/O read and 4'b0001 for an I/O write.
- R8: Read data is captured from the card on the clock edge at which the strobe negates. It is held on the read data output until the next read, and a write access leaves it unchanged.
- R9: The acknowledge is high for exactly one clock, in the clock after the last hold clock, with chip-enable already low in that clock.
- R10: A request is accepted only while no access is running and the acknowledge is low. Changes to the request address during an access do not reach the card address output.
- R11: The data-drive enable is high for the whole of a write access, from setup through hold, and low throughout a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, held until acknowledge |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr_i | input | ADDR_W | Card address |
| req_wdata_i | input | DATA_W | Write data |
| tm_setup_i | input | SETUP_W | Setup clocks of the window |
| tm_len_i | input | LEN_W | Minimum strobe clocks of the window |
| tm_hold_i | input | HOLD_W | Hold clocks of the window |
| tm_wait_en_i | input | 1 | Honour the card wait input |
| ack_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| card_addr_o | output | ADDR_W | Latched card address |
| card_addr_valid_o | output | 1 | Address valid for the whole access |
| card_ce_o | output | 1 | Chip enable for the whole access |
| card_oe_o | output | 1 | Memory read strobe |
| card_we_o | output | 1 | Memory write strobe |
| card_iord_o | output | 1 | I/O read strobe |
| card_iowr_o | output | 1 | I/O write strobe |
| card_wdata_o | output | DATA_W | Latched write data |
| card_data_oe_o | output | 1 | Host drives the data bus |
| card_rdata_i | input | DATA_W | Data from the card |
| card_wait_i | input | 1 | Card wait, asynchronous |

## Verification
The end of the programmed length and the release of the synchronized wait can fall on the same clock edge. The bench aims the raw wait release so that its synchronized copy drops exactly when the length count expires, and also releases it before and well after that point. It judges each run by counting strobe clocks at the ports against max(length, k+3). Read-data capture and the strobe's negation also share one edge. The card data is switched to a different value in the first hold clock, and the captured word must be the one that was on the bus while the strobe was asserted.

// File: rtl/cstrb_pkg.sv
package cstrb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  // Setup clocks actually spent: I/O writes get one extra clock.
  function automatic int unsigned setup_clocks(int unsigned stp, logic is_io, logic is_wr);
    return stp + ((is_io && is_wr) ? 32'd1 : 32'd0);
  endfunction

  // Strobe never shorter than one clock.
  function automatic int unsigned len_clocks(int unsigned lng);
    return (lng == 0) ? 32'd1 : lng;
  endfunction

  // Hold floor of one clock.
  function automatic int unsigned hold_clocks(int unsigned hld);
    return (hld == 0) ? 32'd1 : hld;
  endfunction

endpackage

// File: rtl/cstrb_sync.sv
module cstrb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[N-2:0], d_i};
  end

  assign q_o = sh[N-1];
endmodule

// File: rtl/cstrb_phase_ctrl.sv
module cstrb_phase_ctrl
  import cstrb_pkg::*;
#(
  parameter int SETUP_W = 4,
  parameter int LEN_W   = 6,
  parameter int HOLD_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               is_io_i,
  input  logic               is_wr_i,
  input  logic [SETUP_W-1:0] setup_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [HOLD_W-1:0]  hold_i,
  input  logic               wait_en_i,
  input  logic               wait_s_i,
  output phase_e             phase_o,
  output logic               len_done_o,
  output logic               strobe_end_o,
  output logic               hold_end_o
);
  localparam int SW1   = SETUP_W + 1;
  localparam int CNT_W = (SW1 > LEN_W) ? ((SW1 > HOLD_W) ? SW1 : HOLD_W)
                                       : ((LEN_W > HOLD_W) ? LEN_W : HOLD_W);

  phase_e             ph, ph_n;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic [LEN_W-1:0]   len_q;
  logic [HOLD_W-1:0]  hold_q;
  logic               wen_q;
  logic               stretch;
  int unsigned        first_setup;

  assign first_setup = setup_clocks(32'(setup_i), is_io_i, is_wr_i);
  assign len_done_o  = (ph == PH_STROBE) && (cnt == CNT_W'(1));
  assign stretch     = wen_q && wait_s_i;

  always_comb begin
    ph_n         = ph;
    cnt_n        = cnt;
    strobe_end_o = 1'b0;
    hold_end_o   = 1'b0;
    unique case (ph)
      PH_IDLE: begin
        if (start_i) begin
          if (first_setup == 0) begin
            ph_n  = PH_STROBE;
            cnt_n = CNT_W'(len_clocks(32'(len_i)));
          end else begin
            ph_n  = PH_SETUP;
            cnt_n = CNT_W'(first_setup);
          end
        end
      end
      PH_SETUP: begin
        if (cnt == CNT_W'(1)) begin
          ph_n  = PH_STROBE;
          cnt_n = CNT_W'(len_clocks(32'(len_q)));
        end else begin
          cnt_n = cnt - CNT_W'(1);
        end
      end
      PH_STROBE: begin
        if (!len_done_o) begin
          cnt_n = cnt - CNT_W'(1);
        end else if (!stretch) begin
          ph_n         = PH_HOLD;
          cnt_n        = CNT_W'(hold_clocks(32'(hold_q)));
          strobe_end_o = 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt == CNT_W'(1)) begin
          ph_n       = PH_IDLE;
          hold_end_o = 1'b1;
        end else begin
          cnt_n = cnt - CNT_W'(1);
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      len_q  <= '0;
      hold_q <= '0;
      wen_q  <= 1'b0;
    end else begin
      ph  <= ph_n;
      cnt <= cnt_n;
      if (start_i && ph == PH_IDLE) begin
        len_q  <= len_i;
        hold_q <= hold_i;
        wen_q  <= wait_en_i;
      end
    end
  end

  assign phase_o = ph;

  // Strobe clock counter used only by the checks below.
  logic [15:0] str_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 str_run <= '0;
    else if (ph != PH_STROBE)   str_run <= '0;
    else if (str_run != '1)     str_run <= str_run + 16'd1;
  end

  p_len_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_end_o |-> (32'(str_run) + 1 >= len_clocks(32'(len_q))));

  p_wait_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (len_done_o && wen_q && wait_s_i) |=> (ph == PH_STROBE));

  p_hold_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_end_o |=> (ph == PH_HOLD));

  p_hold_ends_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_end_o |=> (ph == PH_IDLE));
endmodule

// File: rtl/cstrb_strobe_dec.sv
module cstrb_strobe_dec
  import cstrb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_i,
  input  logic   is_io_i,
  input  logic   is_wr_i,
  output logic   oe_o,
  output logic   we_o,
  output logic   iord_o,
  output logic   iowr_o,
  output logic   active_o
);
  logic on;

  assign on       = (phase_i == PH_STROBE);
  assign active_o = (phase_i != PH_IDLE);
  assign oe_o     = on && !is_io_i && !is_wr_i;
  assign we_o     = on && !is_io_i &&  is_wr_i;
  assign iord_o   = on &&  is_io_i && !is_wr_i;
  assign iowr_o   = on &&  is_io_i &&  is_wr_i;

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({oe_o, we_o, iord_o, iowr_o}));

  p_strobe_in_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o || we_o || iord_o || iowr_o) |-> active_o);
endmodule

// File: rtl/card_strobe_seq.sv
module card_strobe_seq
  import cstrb_pkg::*;
#(
  parameter int ADDR_W      = 26,
  parameter int DATA_W      = 16,
  parameter int SETUP_W     = 4,
  parameter int LEN_W       = 6,
  parameter int HOLD_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic               req_wr_i,
  input  logic               req_io_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  input  logic [SETUP_W-1:0] tm_setup_i,
  input  logic [LEN_W-1:0]   tm_len_i,
  input  logic [HOLD_W-1:0]  tm_hold_i,
  input  logic               tm_wait_en_i,
  output logic               ack_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [ADDR_W-1:0]  card_addr_o,
  output logic               card_addr_valid_o,
  output logic               card_ce_o,
  output logic               card_oe_o,
  output logic               card_we_o,
  output logic               card_iord_o,
  output logic               card_iowr_o,
  output logic [DATA_W-1:0]  card_wdata_o,
  output logic               card_data_oe_o,
  input  logic [DATA_W-1:0]  card_rdata_i,
  input  logic               card_wait_i
);
  phase_e             phase;
  logic               accept;
  logic               wait_s;
  logic               len_done;
  logic               ev_strobe_end;
  logic               ev_hold_end;
  logic               busy;
  logic               ack_q;
  logic               wr_q, io_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;

  assign accept = req_i && (phase == PH_IDLE) && !ack_q;

  cstrb_sync #(.STAGES(SYNC_STAGES)) u_wait_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (card_wait_i),
    .q_o   (wait_s)
  );

  cstrb_phase_ctrl #(
    .SETUP_W (SETUP_W),
    .LEN_W   (LEN_W),
    .HOLD_W  (HOLD_W)
  ) u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (accept),
    .is_io_i      (req_io_i),
    .is_wr_i      (req_wr_i),
    .setup_i      (tm_setup_i),
    .len_i        (tm_len_i),
    .hold_i       (tm_hold_i),
    .wait_en_i    (tm_wait_en_i),
    .wait_s_i     (wait_s),
    .phase_o      (phase),
    .len_done_o   (len_done),
    .strobe_end_o (ev_strobe_end),
    .hold_end_o   (ev_hold_end)
  );

  cstrb_strobe_dec u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_i  (phase),
    .is_io_i  (io_q),
    .is_wr_i  (wr_q),
    .oe_o     (card_oe_o),
    .we_o     (card_we_o),
    .iord_o   (card_iord_o),
    .iowr_o   (card_iowr_o),
    .active_o (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      io_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= ev_hold_end;
      if (accept) begin
        wr_q    <= req_wr_i;
        io_q    <= req_io_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (ev_strobe_end && !wr_q) rdata_q <= card_rdata_i;
    end
  end

  assign ack_o             = ack_q;
  assign rdata_o           = rdata_q;
  assign card_addr_o       = addr_q;
  assign card_wdata_o      = wdata_q;
  assign card_ce_o         = busy;
  assign card_addr_valid_o = busy;
  assign card_data_oe_o    = busy && wr_q;

  p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  p_ack_after_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !card_ce_o);

  p_addr_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(card_addr_o));

  p_drive_in_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    card_data_oe_o |-> card_ce_o);

  p_capture_at_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_strobe_end |-> len_done);
endmodule

// File: tb/tb_card_strobe_seq.sv
module tb_card_strobe_seq;
  localparam int AW = 26;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_i = 1'b0, req_wr_i = 1'b0, req_io_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic [3:0]    tm_setup_i = '0;
  logic [5:0]    tm_len_i = '0;
  logic [2:0]    tm_hold_i = '0;
  logic          tm_wait_en_i = 1'b0;
  logic          ack_o;
  logic [DW-1:0] rdata_o;
  logic [AW-1:0] card_addr_o;
  logic          card_addr_valid_o, card_ce_o, card_oe_o, card_we_o, card_iord_o, card_iowr_o;
  logic [DW-1:0] card_wdata_o;
  logic          card_data_oe_o;
  logic [DW-1:0] card_rdata_i = '0;
  logic          card_wait_i = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  logic [DW-1:0] last_read = '0;

  always #5 clk = ~clk;

  card_strobe_seq dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_setup(int s, bit io, bit wr);
    return (io && wr) ? s + 1 : s;
  endfunction

  function automatic int exp_len(int l, bit wen, int k);
    int base = (l < 1) ? 1 : l;
    if (wen && (k + 3 > base)) return k + 3;
    return base;
  endfunction

  function automatic int exp_hold(int h);
    return (h < 1) ? 1 : h;
  endfunction

  function automatic logic [3:0] exp_vec(bit io, bit wr);
    if (io) return wr ? 4'b0001 : 4'b0010;
    return wr ? 4'b0100 : 1'b1 << 3;
  endfunction

  // k: strobe clock index in which raw wait drops; 1000 keeps it high all strobe.
  task automatic run_access(input bit wr, input bit io, input int s, input int l,
                            input int h, input bit wen, input int k);
    logic [AW-1:0] a = AW'($urandom);
    logic [DW-1:0] rv = DW'($urandom);
    int sc = 0, lc = 0, hc = 0, cyc = 0;
    int vec_bad = 0, addr_bad = 0, doe_bad = 0;
    bit seen_strobe = 0, got_ack = 0;
    logic [3:0] v;
    @(negedge clk);
    card_wait_i  = (k >= 0);
    @(negedge clk);
    req_wr_i = wr; req_io_i = io; req_addr_i = a; req_wdata_i = DW'($urandom);
    tm_setup_i = 4'(s); tm_len_i = 6'(l); tm_hold_i = 3'(h); tm_wait_en_i = wen;
    card_rdata_i = rv;
    req_i = 1'b1;
    while (!got_ack && cyc < 400) begin
      @(negedge clk);
      cyc++;
      v = {card_oe_o, card_we_o, card_iord_o, card_iowr_o};
      if (ack_o) begin
        got_ack = 1;
        check(!card_ce_o, "R9 ce low with ack", card_ce_o, 0);
        req_i = 1'b0;
        card_wait_i = 1'b0;
      end else if (card_ce_o) begin
        if (card_addr_o !== a) addr_bad++;
        if (card_data_oe_o !== wr) doe_bad++;
        if (v != 4'b0) begin
          if (v !== exp_vec(io, wr)) vec_bad++;
          if (lc == k) card_wait_i = 1'b0;
          lc++;
          seen_strobe = 1;
          req_addr_i = AW'($urandom);
        end else if (!seen_strobe) sc++;
        else begin
          if (hc == 0) card_rdata_i = ~rv;
          hc++;
        end
      end
    end
    if (!got_ack) check(0, "R9 watchdog ack", 0, 1);
    if (io && wr) check(sc == exp_setup(s, io, wr), "R3 io write setup", sc, exp_setup(s, io, wr));
    else          check(sc == exp_setup(s, io, wr), "R2 setup clocks", sc, exp_setup(s, io, wr));
    if (wen) check(lc == exp_len(l, wen, k), "R5 wait strobe length", lc, exp_len(l, wen, k));
    else     check(lc == exp_len(l, 0, k), "R4 strobe length", lc, exp_len(l, 0, k));
    check(hc == exp_hold(h), "R6 hold clocks", hc, exp_hold(h));
    check(vec_bad == 0, "R7 strobe select", vec_bad, 0);
    check(addr_bad == 0, "R10 address frozen", addr_bad, 0);
    check(doe_bad == 0, "R11 data drive", doe_bad, 0);
    if (!wr) last_read = rv;
    check(rdata_o === last_read, "R8 read capture", rdata_o, last_read);
    @(negedge clk);
    check(!ack_o && !card_ce_o, "R9 ack one clock", ack_o, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1DEC0DE));
    repeat (3) @(negedge clk);
    check({ack_o, card_ce_o, card_addr_valid_o, card_data_oe_o, card_oe_o, card_we_o,
           card_iord_o, card_iowr_o} == 8'h00, "R1 reset outputs", card_ce_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!ack_o && !card_ce_o && !card_addr_valid_o, "R1 idle after reset", card_ce_o, 0);
    // Directed corners
    run_access(0, 0, 0, 0, 0, 0, -1);     // floors: R2 R4 R6
    run_access(1, 1, 0, 0, 0, 0, -1);     // R3 setup 0 becomes 1
    run_access(1, 1, 15, 63, 7, 0, -1);   // R3 maxima
    run_access(0, 1, 3, 2, 2, 1, 10);     // R5 wait dominates
    run_access(0, 0, 2, 6, 1, 1, 3);      // R5 release lands as length expires
    run_access(1, 0, 1, 8, 3, 1, 0);      // R5 early release, length dominates
    run_access(0, 1, 2, 3, 2, 0, 1000);   // R5 wait ignored when disabled
    run_access(1, 0, 4, 5, 0, 0, -1);     // R8 write keeps read data
    // Random mix
    for (int i = 0; i < 40; i++) begin
      bit wr = 1'($urandom);
      bit io = 1'($urandom);
      bit wen = 1'($urandom);
      int k = wen ? int'($urandom % 12) : (($urandom % 2) ? 1000 : -1);
      run_access(wr, io, int'($urandom % 16), int'($urandom % 64), int'($urandom % 8), wen, k);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule